// File: doc/BRIEF.md
# 1-Wire ROM Search Triplet Accelerator

This block sits next to a 1-Wire bus master and takes over the bit-level work of a ROM search. Once the host has reset the bus and sent the search command byte through the ordinary master path, it raises the accelerator enable. From then on, each byte the host writes starts four search triplets on the bus. In each triplet the block reads an ID bit, then reads its complement, and then writes back the bit it picked.

After all twelve time slots are done, the block hands back one byte. That byte holds the four chosen ROM bits and a discrepancy flag for each of them. Sixteen transfers cover a 64-bit ROM identifier, and transfer i gives ID bits [4i+3:4i]. The host picks the direction to take at each conflict through the odd bit positions of the byte it writes. Writing 0x00 every time follows the 0 branch throughout. Deciding the next search path is left to software.

The bus is open-drain. The block asserts `bus_pull_low` to pull the line low and reads the line level on `bus_sense`. `bus_sense` is assumed to be already synchronous to `clk`. Slot timing is built from cycle counts, with one set for standard speed and a shorter set for overdrive speed.

Top module: `srch_accel`

## Requirements
- R1: After reset, `bus_pull_low`, `busy` and `rx_full` are 0 and `rd_data` is 0x00.
- R2: A `wr_strobe` while `accel_en` is 0 is ignored: no bus slot is started, `busy` stays 0 and `rx_full` stays 0.
- R3: A write accepted while idle and enabled runs exactly 12 bus slots, in the order read, read, write for each of the four triplets.
- R4: If a triplet reads bit 0 then complement 1, the chosen bit is 0. If it reads 1 then 0, the chosen bit is 1. In both cases the discrepancy flag is 0.
- R5: If a triplet reads 0 then 0, the discrepancy flag is 1 and the chosen bit is the host's preferred bit. For triplet k the preferred bit is `wr_data[2k+1]`.
- R6: If a triplet reads 1 then 1 (no device answering), the discrepancy flag is 1 and the chosen bit is 1.
- R7: In the result byte, triplet k (k=0 first on the bus) puts its chosen bit at bit 2k+1 and its discrepancy flag at bit 2k.
- R8: `rd_data` is loaded and `rx_full` is set only in the cycle `busy` falls, after the twelfth slot has finished. `rd_data` holds its value while `busy` is 1.
- R9: A `rd_strobe` while `busy` is 0 clears `rx_full`.
- R10: In the write slot of each triplet, the block holds the line low for the write-0 time when the chosen bit is 0 and for the short write-1 time when it is 1. Read slots use the short low time and sample `bus_sense` at the sample point.
- R11: `overdrive`, captured when a write is accepted, makes all twelve slots use the shorter overdrive timing set.
- R12: A `wr_strobe` while `busy` is 1 is ignored. The running transfer finishes with the result of the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| accel_en | input | 1 | Accelerator mode enable (command bit) |
| overdrive | input | 1 | Use overdrive slot timing for the next transfer |
| wr_strobe | input | 1 | Host writes the direction byte |
| wr_data | input | 8 | Direction byte; odd bits give the preferred bit for each triplet |
| rd_strobe | input | 1 | Host reads the result byte; clears `rx_full` |
| rd_data | output | 8 | Result: chosen bits on odd positions, discrepancy flags on even positions |
| rx_full | output | 1 | Result byte available |
| busy | output | 1 | Triplets in progress |
| bus_pull_low | output | 1 | Pull the 1-Wire line low |
| bus_sense | input | 1 | Level seen on the 1-Wire line |

## Verification
The bench models the devices on the bus. It answers each read slot with a scripted bit pair and measures how long the block holds the line low in each write slot. This catches a design that swaps the bit and its complement, writes back the wrong branch, or drops or adds a slot. The conflict cases are run with preferred bytes that differ per triplet, such as 0x82. A design that takes the preference from the wrong bit position, or that mixes up the 0/0 case with the 1/1 case, returns the wrong byte. The bench also writes a second byte in the middle of a transfer, checks that `rx_full` cannot rise before the twelfth slot, and compares overdrive with standard run lengths. Early flags, lost first results and speed settings that are never applied all show up.

// File: rtl/srch_pkg.sv
// Shared types and the triplet decision rule for the ROM search accelerator.
// Assumes: four triplets per host transfer, one result byte per transfer.
package srch_pkg;
    localparam int TRIPLETS = 4;
    localparam int KW       = $clog2(TRIPLETS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_READ_ID   = 2'd0,
        PH_READ_CMP  = 2'd1,
        PH_WRITE_DIR = 2'd2
    } phase_t;

    // Returns {chosen, discrepancy} for one triplet.
    function automatic logic [1:0] pick_branch(input logic id_bit,
                                               input logic cmp_bit,
                                               input logic pref_bit);
        logic [1:0] r;
        unique case ({id_bit, cmp_bit})
            2'b01:   r = 2'b00;
            2'b10:   r = 2'b10;
            2'b00:   r = {pref_bit, 1'b1};
            default: r = 2'b11;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/owl_timing_sel.sv
// Picks the slot timing set (standard or overdrive) as cycle counts.
// Assumes: low1 < sample < low0 < slot length in both sets.
module owl_timing_sel #(
    parameter int STD_LOW1 = 6,
    parameter int STD_SAMP = 12,
    parameter int STD_LOW0 = 50,
    parameter int STD_SLOT = 60,
    parameter int STD_REC  = 4,
    parameter int OD_LOW1  = 1,
    parameter int OD_SAMP  = 2,
    parameter int OD_LOW0  = 7,
    parameter int OD_SLOT  = 9,
    parameter int OD_REC   = 2,
    parameter int CW       = $clog2(STD_SLOT + STD_REC + 1)
) (
    input  logic          od,
    output logic [CW-1:0] len_low1,
    output logic [CW-1:0] len_low0,
    output logic [CW-1:0] len_samp,
    output logic [CW-1:0] len_last
);
    localparam int STD_LAST = STD_SLOT + STD_REC - 1;
    localparam int OD_LAST  = OD_SLOT + OD_REC - 1;

    // Select the active timing set.
    always_comb begin
        if (od) begin
            len_low1 = CW'(OD_LOW1);
            len_low0 = CW'(OD_LOW0);
            len_samp = CW'(OD_SAMP);
            len_last = CW'(OD_LAST);
        end else begin
            len_low1 = CW'(STD_LOW1);
            len_low0 = CW'(STD_LOW0);
            len_samp = CW'(STD_SAMP);
            len_last = CW'(STD_LAST);
        end
    end
endmodule

// File: rtl/owl_slot_engine.sv
// Runs one 1-Wire time slot. The low time depends on the bit written
// (a read slot is a write-1 slot). The line is sampled at the sample count,
// and done pulses on the last cycle of recovery.
// Assumes: start is only raised while idle; bus_sense is synchronous.
module owl_slot_engine #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wbit,
    input  logic [CW-1:0] len_low1,
    input  logic [CW-1:0] len_low0,
    input  logic [CW-1:0] len_samp,
    input  logic [CW-1:0] len_last,
    input  logic          bus_sense,
    output logic          pull_low,
    output logic          done,
    output logic          samp
);
    logic          active;
    logic [CW-1:0] cnt;
    logic          bit_q;

    // Slot counter, bit latch and sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            bit_q  <= 1'b1;
            samp   <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                bit_q  <= wbit;
            end
        end else begin
            if (cnt == len_samp) samp <= bus_sense;
            if (cnt == len_last) active <= 1'b0;
            else                 cnt    <= cnt + 1'b1;
        end
    end

    // Line drive and end-of-slot pulse.
    always_comb begin
        pull_low = active && (cnt < (bit_q ? len_low1 : len_low0));
        done     = active && (cnt == len_last);
    end
endmodule

// File: rtl/srch_triplet_seq.sv
// Sequences four read/read/write triplets per host byte, decides each
// branch and packs the result byte (chosen at 2k+1, flag at 2k).
// Assumes: the slot engine accepts start one cycle after done.
module srch_triplet_seq
    import srch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accel_en,
    input  logic       od_in,
    input  logic       wr_strobe,
    input  logic [7:0] wr_data,
    input  logic       rd_strobe,
    input  logic       eng_done,
    input  logic       eng_samp,
    output logic       eng_start,
    output logic       eng_wbit,
    output logic       od_q,
    output logic [7:0] rd_data,
    output logic       rx_full,
    output logic       busy
);
    seq_state_t          state;
    phase_t              phase;
    logic [KW-1:0]       k;
    logic [TRIPLETS-1:0] pref;
    logic                id_q;
    logic                cur_pick;
    logic                cur_disc;
    logic [7:0]          acc;
    logic [7:0]          acc_next;
    logic                finish;

    // Fold the current triplet into the result byte.
    always_comb begin
        acc_next = acc;
        acc_next[{k, 1'b1}] = cur_pick;
        acc_next[{k, 1'b0}] = cur_disc;
    end

    // Engine controls and completion.
    always_comb begin
        eng_start = (state == ST_ISSUE);
        eng_wbit  = (phase == PH_WRITE_DIR) ? cur_pick : 1'b1;
        busy      = (state != ST_IDLE);
        finish    = (state == ST_WAIT) && eng_done && (phase == PH_WRITE_DIR)
                    && (k == KW'(TRIPLETS - 1));
    end

    // Main triplet state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_READ_ID;
            k        <= '0;
            pref     <= '0;
            id_q     <= 1'b0;
            cur_pick <= 1'b0;
            cur_disc <= 1'b0;
            acc      <= '0;
            od_q     <= 1'b0;
            rd_data  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_strobe && accel_en) begin
                        for (int i = 0; i < TRIPLETS; i++) pref[i] <= wr_data[2*i+1];
                        od_q  <= od_in;
                        k     <= '0;
                        phase <= PH_READ_ID;
                        acc   <= '0;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (eng_done) begin
                        unique case (phase)
                            PH_READ_ID: begin
                                id_q  <= eng_samp;
                                phase <= PH_READ_CMP;
                                state <= ST_ISSUE;
                            end
                            PH_READ_CMP: begin
                                {cur_pick, cur_disc} <= pick_branch(id_q, eng_samp, pref[k]);
                                phase <= PH_WRITE_DIR;
                                state <= ST_ISSUE;
                            end
                            default: begin
                                acc <= acc_next;
                                if (finish) begin
                                    rd_data <= acc_next;
                                    state   <= ST_IDLE;
                                end else begin
                                    k     <= k + 1'b1;
                                    phase <= PH_READ_ID;
                                    state <= ST_ISSUE;
                                end
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Receive-full flag: set on completion, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_full <= 1'b0;
        else if (finish)    rx_full <= 1'b1;
        else if (rd_strobe) rx_full <= 1'b0;
    end
endmodule

// File: rtl/srch_accel.sv
// Top of the ROM search accelerator: triplet sequencer, timing selection
// and one slot engine driving the open-drain line.
// Assumes: bus reset and search command are done by the master beforehand.
module srch_accel #(
    parameter int STD_LOW1 = 6,
    parameter int STD_SAMP = 12,
    parameter int STD_LOW0 = 50,
    parameter int STD_SLOT = 60,
    parameter int STD_REC  = 4,
    parameter int OD_LOW1  = 1,
    parameter int OD_SAMP  = 2,
    parameter int OD_LOW0  = 7,
    parameter int OD_SLOT  = 9,
    parameter int OD_REC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accel_en,
    input  logic       overdrive,
    input  logic       wr_strobe,
    input  logic [7:0] wr_data,
    input  logic       rd_strobe,
    output logic [7:0] rd_data,
    output logic       rx_full,
    output logic       busy,
    output logic       bus_pull_low,
    input  logic       bus_sense
);
    localparam int CW = $clog2(STD_SLOT + STD_REC + 1);

    logic          eng_start, eng_wbit, eng_done, eng_samp, od_q;
    logic [CW-1:0] len_low1, len_low0, len_samp, len_last;

    srch_triplet_seq seq_i (
        .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .od_in(overdrive),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .eng_done(eng_done), .eng_samp(eng_samp), .eng_start(eng_start),
        .eng_wbit(eng_wbit), .od_q(od_q), .rd_data(rd_data),
        .rx_full(rx_full), .busy(busy)
    );

    owl_timing_sel #(
        .STD_LOW1(STD_LOW1), .STD_SAMP(STD_SAMP), .STD_LOW0(STD_LOW0),
        .STD_SLOT(STD_SLOT), .STD_REC(STD_REC), .OD_LOW1(OD_LOW1),
        .OD_SAMP(OD_SAMP), .OD_LOW0(OD_LOW0), .OD_SLOT(OD_SLOT),
        .OD_REC(OD_REC), .CW(CW)
    ) tsel_i (
        .od(od_q), .len_low1(len_low1), .len_low0(len_low0),
        .len_samp(len_samp), .len_last(len_last)
    );

    owl_slot_engine #(.CW(CW)) eng_i (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .wbit(eng_wbit),
        .len_low1(len_low1), .len_low0(len_low0), .len_samp(len_samp),
        .len_last(len_last), .bus_sense(bus_sense), .pull_low(bus_pull_low),
        .done(eng_done), .samp(eng_samp)
    );
endmodule

// File: rtl/srch_accel_chk.sv
// Port-level properties of the search accelerator, bound to the top.
module srch_accel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       accel_en,
    input logic       overdrive,
    input logic       wr_strobe,
    input logic [7:0] wr_data,
    input logic       rd_strobe,
    input logic [7:0] rd_data,
    input logic       rx_full,
    input logic       busy,
    input logic       bus_pull_low,
    input logic       bus_sense
);
    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rx_full && !busy && !bus_pull_low));

    // R2: disabled writes never start a transfer
    a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!accel_en && !busy) |=> !busy);

    // R3: the line is only driven during a transfer
    a_r3_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_low |-> busy);

    // R8: flag rises only as the transfer ends
    a_r8_full_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $fell(busy));

    // R8: result byte changes only as the transfer ends
    a_r8_data_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $fell(busy));

    // R9: host read while idle clears the flag
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !busy) |=> !rx_full);
endmodule

bind srch_accel srch_accel_chk chk_i (.*);

// File: tb/srch_accel_tb.sv
// Directed bench for srch_accel with a scripted bus device model.
module srch_accel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       accel_en = 1'b0, overdrive = 1'b0, wr_strobe = 1'b0, rd_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rx_full, busy, bus_pull_low, bus_sense;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    srch_accel dut_i (
        .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .overdrive(overdrive),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_full(rx_full), .busy(busy),
        .bus_pull_low(bus_pull_low), .bus_sense(bus_sense)
    );

    // Device model: scripted answers for read slots; measures write slots.
    logic [3:0] resp_id, resp_cmp;
    logic       model_od = 1'b0;
    logic       dev_low = 1'b0;
    int         dev_hold = 0;
    int         slot_idx = 0;
    int         low_cnt = 0;
    logic       prev_pull = 1'b0;
    logic [3:0] seen_wbit = 4'h0;

    assign bus_sense = !(bus_pull_low || dev_low);

    always @(negedge clk) begin
        if (bus_pull_low && !prev_pull) begin
            low_cnt = 1;
            if (slot_idx % 3 != 2) begin
                if (!((slot_idx % 3 == 0) ? resp_id[slot_idx/3] : resp_cmp[slot_idx/3]))
                    dev_hold = model_od ? 3 : 20;
            end
        end else if (bus_pull_low) begin
            low_cnt++;
        end else if (prev_pull) begin
            if (slot_idx % 3 == 2 && slot_idx / 3 < 4)
                seen_wbit[slot_idx/3] = (low_cnt > (model_od ? 4 : 25)) ? 1'b0 : 1'b1;
            slot_idx++;
        end
        prev_pull = bus_pull_low;
        if (dev_hold > 0) begin dev_low = 1'b1; dev_hold--; end
        else dev_low = 1'b0;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pick(input logic a, input logic b, input logic p);
        if (a == 1'b0 && b == 1'b1) return 2'b00;
        if (a == 1'b1 && b == 1'b0) return 2'b10;
        if (a == 1'b0 && b == 1'b0) return {p, 1'b1};
        return 2'b11;
    endfunction

    // Runs one transfer and checks result, write bits, slot count and flags.
    task automatic run_xfer(input string req, input logic [3:0] a, input logic [3:0] b,
                            input logic [7:0] wr, input logic od, input bit poke,
                            output int cycles);
        logic [7:0] exp_byte;
        logic [3:0] exp_w;
        logic [1:0] pr;
        bit early_full;
        exp_byte = 8'h00;
        for (int k = 0; k < 4; k++) begin
            pr = exp_pick(a[k], b[k], wr[2*k+1]);
            exp_byte[2*k+1] = pr[1];
            exp_byte[2*k]   = pr[0];
            exp_w[k]        = pr[1];
        end
        @(negedge clk);
        resp_id = a; resp_cmp = b; model_od = od; slot_idx = 0; seen_wbit = 4'h0;
        overdrive = od; wr_data = wr; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0; overdrive = 1'b0;
        cycles = 0; early_full = 0;
        while (busy) begin
            if (rx_full) early_full = 1;
            if (poke && cycles == 40) begin wr_data = ~wr; wr_strobe = 1'b1; end
            else wr_strobe = 1'b0;
            cycles++;
            @(negedge clk);
        end
        wr_strobe = 1'b0;
        check({req, "/R8"}, "rx_full before end", int'(early_full), 0);
        check({req, "/R8"}, "rx_full after end", int'(rx_full), 1);
        check({req, "/R7"}, "result byte", int'(rd_data), int'(exp_byte));
        check({req, "/R3"}, "slot count", slot_idx, 12);
        check({req, "/R10"}, "written bits", int'(seen_wbit), int'(exp_w));
        repeat (3) @(negedge clk);
        check({req, "/R12"}, "no second run", int'(busy), 0);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check({req, "/R9"}, "rx_full cleared", int'(rx_full), 0);
    endtask

    task automatic t_reset_state();
        check("R1", "bus_pull_low", int'(bus_pull_low), 0);
        check("R1", "busy", int'(busy), 0);
        check("R1", "rx_full", int'(rx_full), 0);
        check("R1", "rd_data", int'(rd_data), 0);
    endtask

    task automatic t_disabled_write();
        accel_en = 1'b0;
        slot_idx = 0;
        @(negedge clk);
        wr_data = 8'hAA; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        repeat (100) @(negedge clk);
        check("R2", "slots while disabled", slot_idx, 0);
        check("R2", "busy while disabled", int'(busy), 0);
        check("R2", "rx_full while disabled", int'(rx_full), 0);
        accel_en = 1'b1;
    endtask

    task automatic t_clean_bits();
        int c;
        run_xfer("R4", 4'b0110, 4'b1001, 8'h00, 1'b0, 0, c);
        run_xfer("R4", 4'b1001, 4'b0110, 8'hAA, 1'b0, 0, c);
    endtask

    task automatic t_conflicts();
        int c;
        run_xfer("R5", 4'b0000, 4'b0000, 8'h00, 1'b0, 0, c);
        run_xfer("R5", 4'b0000, 4'b0000, 8'hAA, 1'b0, 0, c);
        run_xfer("R5", 4'b0000, 4'b0000, 8'h82, 1'b0, 0, c);
        run_xfer("R5", 4'b0010, 4'b0100, 8'h08, 1'b0, 0, c);
    endtask

    task automatic t_absent();
        int c;
        run_xfer("R6", 4'b1111, 4'b1111, 8'h00, 1'b0, 0, c);
        run_xfer("R6", 4'b1100, 4'b1101, 8'h00, 1'b0, 0, c);
    endtask

    task automatic t_overdrive();
        int c_std, c_od;
        run_xfer("R11", 4'b0101, 4'b0010, 8'h20, 1'b0, 0, c_std);
        run_xfer("R11", 4'b0101, 4'b0010, 8'h20, 1'b1, 0, c_od);
        check("R11", "overdrive shorter", int'(c_od * 3 < c_std), 1);
    endtask

    task automatic t_busy_write();
        int c;
        run_xfer("R12", 4'b0011, 4'b0001, 8'h22, 1'b0, 1, c);
    endtask

    initial begin
        resp_id = 4'h0; resp_cmp = 4'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_disabled_write();
        t_clean_bits();
        t_conflicts();
        t_absent();
        t_overdrive();
        t_busy_write();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule